// File: doc/BRIEF.md
# Burst Address Generator with Dual Load Strobes

This block supplies the word address for a pipelined synchronous memory that serves four-beat bursts. A start address and the state of three chip enables are captured at a rising clock edge when one of two active-low load strobes is asserted. One strobe is meant for a processor and the other for a memory controller. After the load, an active-low advance input steps a two-bit beat counter. The counter replaces the two least significant address bits. The upper address bits stay fixed for the whole burst.

A static mode input chooses the beat order. In interleaved order, the start bits are XORed with the beat number. In linear order, the beat number is added to the start bits modulo four. The processor strobe is qualified by the first chip enable. The controller strobe is not. A registered chip-selected flag reports whether all three enables were asserted at the last load.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with no load, addr_out is all zeros and chip_sel is 0.
- R2: When ctrl_strb_n is 0 at a rising edge, addr_in is captured whatever cs1_n is. In the following cycle addr_out equals that addr_in, and the beat number is 0.
- R3: When proc_strb_n is 0 at an edge, addr_in is captured only if cs1_n is 0. If cs1_n is 1 and ctrl_strb_n is 1, the processor strobe has no effect on addr_out or chip_sel.
- R4: At every load, chip_sel becomes 1 exactly when cs1_n=0, cs2=1 and cs3_n=0 are sampled at that edge. chip_sel holds its value in all other cycles.
- R5: With no load at an edge, adv_n=0 increments the beat number by one. adv_n=1 leaves addr_out unchanged.
- R6: With mode_lin=0 (interleaved), addr_out[1:0] equals start[1:0] XOR beat. For example, a start of 01 gives 01, 00, 11, 10.
- R7: With mode_lin=1 (linear), addr_out[1:0] equals (start[1:0] + beat) mod 4. For example, a start of 11 gives 11, 00, 01, 10.
- R8: A load at the same edge as adv_n=0 takes priority and restarts the burst at beat 0.
- R9: After the fourth beat, further advances wrap within the same four-word group. addr_out[ADDR_W-1:2] changes only at a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_strb_n | input | 1 | Processor load strobe, active low, qualified by cs1_n |
| ctrl_strb_n | input | 1 | Controller load strobe, active low, unqualified |
| adv_n | input | 1 | Burst advance, active low |
| mode_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| cs1_n | input | 1 | First chip enable, active low |
| cs2 | input | 1 | Second chip enable, active high |
| cs3_n | input | 1 | Third chip enable, active low |
| addr_in | input | ADDR_W | Start address sampled at a load |
| addr_out | output | ADDR_W | Current word address of the burst |
| chip_sel | output | 1 | Registered all-enables-true flag from the last load |

## Verification
The assertions check every cycle that:
- a load puts the sampled address on addr_out in the next cycle;
- a cycle with no load and no advance changes neither output;
- a processor strobe blocked by cs1_n leaves the state untouched;
- the upper address bits never move without a load;
- in linear mode an advance adds one to the low bits;
- chip_sel follows the enables sampled at the load.

The interleaved XOR order is checked only by the bench's directed and random scenarios. So are the wrap after the fourth beat and the strobe-over-advance priority. These need the start bits and the beat count of a whole burst, which a single-cycle property cannot see.

// File: rtl/bag_pkg.sv
// Package for the burst address generator.
// Holds the burst-order type and the mapping from start bits and beat number
// to the low address bits. It assumes bursts of four beats (two low bits).
package bag_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_ADD = 1'b1
    } burst_order_e;

    // Low address bits for a given start value, beat number and burst order.
    function automatic logic [BEAT_W-1:0] beat_low_bits(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input burst_order_e      order
    );
        if (order == ORDER_ADD) return start + beat;
        return start ^ beat;
    endfunction
endpackage

// File: rtl/bag_strobe_arb.sv
// Strobe arbitration for the burst address generator.
// Decides whether this edge loads a new start address, and computes the
// chip-selected value to capture with it. The processor strobe counts only
// while cs1_n is low. The controller strobe always counts.
// All inputs are assumed synchronous to the clock of the caller.
module bag_strobe_arb (
    input  logic proc_strb_n,
    input  logic ctrl_strb_n,
    input  logic cs1_n,
    input  logic cs2,
    input  logic cs3_n,
    output logic load,
    output logic sel_next
);
    logic proc_ok;
    logic ctrl_ok;

    // Qualify each strobe and combine the enables into one select value.
    always_comb begin
        proc_ok  = !proc_strb_n && !cs1_n;
        ctrl_ok  = !ctrl_strb_n;
        load     = proc_ok || ctrl_ok;
        sel_next = !cs1_n && cs2 && !cs3_n;
    end
endmodule

// File: rtl/bag_beat_ctr.sv
// Beat counter for the burst address generator.
// Clears to zero on a load and otherwise counts up on advance, wrapping
// modulo 2**BEAT_W. A load always wins over an advance in the same cycle.
// Reset is synchronous and active low.
module bag_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    // Restart on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    beat <= '0;
        else if (load) beat <= '0;
        else if (adv)  beat <= beat + BEAT_ONE;
    end
endmodule

// File: rtl/bag_start_reg.sv
// Start-address and chip-select register for the burst address generator.
// Captures the start address and the combined enable value on a load and
// holds both until the next load. Reset is synchronous and active low.
module bag_start_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              sel_d,
    output logic [ADDR_W-1:0] start_q,
    output logic              sel_q
);
    // Capture address and select together at a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            sel_q   <= 1'b0;
        end else if (load) begin
            start_q <= addr_d;
            sel_q   <= sel_d;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator, top level.
// A load from either strobe captures a start address. The two low address
// bits then follow a four-beat burst sequence, stepped by adv_n. The order is
// interleaved or linear, chosen by mode_lin, which is assumed static during a
// burst. Reset is synchronous and active low.
module burst_addr_gen #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              mode_lin,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              chip_sel
);
    import bag_pkg::*;

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              sel_next;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] low_bits;

    bag_strobe_arb u_arb (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .cs1_n       (cs1_n),
        .cs2         (cs2),
        .cs3_n       (cs3_n),
        .load        (load),
        .sel_next    (sel_next)
    );

    bag_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (!adv_n),
        .beat  (beat)
    );

    bag_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_d  (addr_in),
        .sel_d   (sel_next),
        .start_q (start_q),
        .sel_q   (chip_sel)
    );

    // Map the start bits and the beat number onto the low address bits.
    always_comb begin
        low_bits = beat_low_bits(start_q[BEAT_W-1:0], beat,
                                 burst_order_e'(mode_lin));
    end

    // Join the fixed upper bits with the sequenced low bits.
    generate
        if (HI_W > 0) begin : g_hi
            assign addr_out = {start_q[ADDR_W-1:BEAT_W], low_bits};
        end else begin : g_lo_only
            assign addr_out = low_bits[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bag_chk.sv
// Assertion checker for burst_addr_gen, attached with the bind statement below.
// It observes the ports only.
module bag_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strb_n,
    input logic              ctrl_strb_n,
    input logic              adv_n,
    input logic              mode_lin,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              chip_sel
);
    logic ld;
    assign ld = !ctrl_strb_n || (!proc_strb_n && !cs1_n);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> addr_out == $past(addr_in));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_n) |=> ($stable(addr_out) && $stable(chip_sel)));

    // R3
    proc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && cs1_n && ctrl_strb_n && adv_n)
        |=> ($stable(addr_out) && $stable(chip_sel)));

    // R9
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    // R7
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n && mode_lin)
        |=> (!mode_lin || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

    // R4
    select_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> chip_sel == $past(!cs1_n && cs2 && !cs3_n));
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .adv_n       (adv_n),
    .mode_lin    (mode_lin),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .cs3_n       (cs3_n),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .chip_sel    (chip_sel)
);

// File: tb/burst_addr_gen_tb.sv
// Self-checking bench for burst_addr_gen: directed corner cases, then
// seeded random stimulus, compared against a bench-side reference model.
module burst_addr_gen_tb_top;
    localparam int ADDR_W   = 18;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              proc_strb_n = 1'b1;
    logic              ctrl_strb_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              mode_lin = 1'b0;
    logic              cs1_n = 1'b1;
    logic              cs2 = 1'b0;
    logic              cs3_n = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              chip_sel;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [ADDR_W-1:0] m_start = '0;
    logic [1:0]        m_beat  = '0;
    logic              m_sel   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n),
        .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .mode_lin(mode_lin),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .addr_in(addr_in),
        .addr_out(addr_out), .chip_sel(chip_sel)
    );

    // Expected address from the requirement formulas (R6, R7).
    function automatic logic [ADDR_W-1:0] exp_addr(
        input logic [ADDR_W-1:0] s, input logic [1:0] b, input logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(s[1:0] + b) : (s[1:0] ^ b);
        return {s[ADDR_W-1:2], lo};
    endfunction

    task automatic check(input string req, input logic [ADDR_W-1:0] ea,
                         input logic es);
        n_run++;
        if (addr_out !== ea || chip_sel !== es) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h chip_sel=%b expected addr_out=%h chip_sel=%b",
                     req, addr_out, chip_sel, ea, es);
        end
    endtask

    // Apply inputs, take one edge, update the model, compare at the falling edge.
    task automatic step(input logic p_n, input logic c_n, input logic a_n,
                        input logic [ADDR_W-1:0] a, input logic e1_n,
                        input logic e2, input logic e3_n, input string req);
        logic ld;
        proc_strb_n = p_n; ctrl_strb_n = c_n; adv_n = a_n; addr_in = a;
        cs1_n = e1_n; cs2 = e2; cs3_n = e3_n;
        @(posedge clk);
        ld = !c_n || (!p_n && !e1_n);
        if (ld) begin
            m_start = a; m_beat = 2'd0; m_sel = !e1_n && e2 && !e3_n;
        end else if (!a_n) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check(req, exp_addr(m_start, m_beat, mode_lin), m_sel);
    endtask

    // Check one low-bit value of a burst against an explicit expected value.
    task automatic low_is(input logic [1:0] e, input string req);
        n_run++;
        if (addr_out[1:0] !== e) begin
            n_fail++;
            $display("FAIL %s: addr_out[1:0]=%b expected %b", req, addr_out[1:0], e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] base;
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", '0, 1'b0);
        rst_n = 1'b1;
        step(1, 1, 1, 18'h3ABCD, 1, 0, 1, "R1 after reset");

        // R6 interleaved order from start 01, with chip select.
        mode_lin = 1'b0;
        base = 18'h12341;
        step(0, 1, 1, base, 0, 1, 0, "R3 proc load");
        low_is(2'b01, "R6 beat0");
        step(1, 1, 0, '0, 1, 0, 1, "R6"); low_is(2'b00, "R6 beat1");
        step(1, 1, 0, '0, 1, 0, 1, "R6"); low_is(2'b11, "R6 beat2");
        step(1, 1, 0, '0, 1, 0, 1, "R6"); low_is(2'b10, "R6 beat3");
        step(1, 1, 0, '0, 1, 0, 1, "R9 wrap"); low_is(2'b01, "R9 wrap beat");
        step(1, 1, 1, '0, 1, 0, 1, "R5 hold");

        // R7 linear order from start 11 through the ctrl strobe, cs1_n high.
        mode_lin = 1'b1;
        step(1, 0, 1, 18'h0F0F3, 1, 1, 0, "R2 ctrl load");
        low_is(2'b11, "R7 beat0");
        step(1, 1, 0, '0, 0, 1, 0, "R7"); low_is(2'b00, "R7 beat1");
        step(1, 1, 0, '0, 0, 1, 0, "R7"); low_is(2'b01, "R7 beat2");
        step(1, 1, 0, '0, 0, 1, 0, "R7"); low_is(2'b10, "R7 beat3");

        // R3 proc strobe with cs1_n high is ignored.
        step(0, 1, 1, 18'h2AAAA, 1, 1, 0, "R3 ignored");
        // R8 strobe beats advance.
        step(1, 0, 0, 18'h11112, 0, 1, 0, "R8 priority");
        low_is(2'b10, "R8 beat0");
        // R4 each enable off in turn.
        step(1, 0, 1, 18'h00005, 0, 0, 0, "R4 cs2 low");
        step(1, 0, 1, 18'h00006, 0, 1, 1, "R4 cs3_n high");
        step(0, 1, 1, 18'h00007, 0, 1, 0, "R4 all on");

        // Random mix, weighted toward advances.
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) mode_lin = $urandom_range(0, 1);
            step(($urandom_range(0, 5) == 0) ? 1'b0 : 1'b1,
                 ($urandom_range(0, 5) == 0) ? 1'b0 : 1'b1,
                 ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0,
                 ADDR_W'($urandom), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 1), "R5/R6/R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule